// File: doc/BRIEF.md
# Keyed Field-Upgrade Image Loader

This block guards entry into a field-upgrade mode and then moves a fixed-size configuration image, one byte per bus write, toward an external store. After reset it holds a lockout for a set number of milliseconds, counted in clock cycles from a clock-frequency parameter. Once the lockout has passed it raises a ready flag in its status register.

The upgrade opens only when the start register receives three keyed writes in a row with no other register access among them. Idle bus cycles between them are allowed. While the upgrade is open, each write to the data register sends one byte to the byte sink, tagged with its position in the image, and advances a byte counter that software can read back. When the last byte of the image has been taken, the block sets a done flag, closes the upgrade and ignores any further data.

The bus is a plain synchronous register port: one access per cycle with `bus_sel_i` high, and read data returned in the following cycle.

Top module: `fwup_loader`

## Requirements
- R1: Status bit 0 (READY) reads 0 until CLK_HZ/1000*LOCK_MS clock cycles have passed after reset release. After that it reads 1 for as long as the upgrade is neither open nor done.
- R2: Writes to the start register (address 1) made before READY is set are ignored: they do not advance the unlock count (status bits 4:3) and do not open the upgrade.
- R3: With READY set, three writes of 0xA5 to address 1 with no other access between them open the upgrade. Status bit 1 (OPEN) becomes 1 and READY becomes 0. Idle cycles with no access do not break the sequence.
- R4: A write to address 1 carrying any value other than 0xA5 sets the unlock count to 0.
- R5: Before the unlock completes, any other access sets the unlock count to 0. This covers a read of any register, including addresses 0 and 1, and a write to any other address. A status read (address 0) returns the count as it stood before that read.
- R6: While OPEN, each write to the data register (address 2) produces a one-cycle `img_we_o` pulse in the next cycle. The pulse carries the written byte on `img_data_o` and a byte index on `img_idx_o` that starts at 0. The byte count, read at address 3 (low byte) and address 4 (high byte), goes up by one.
- R7: The write of byte number IMG_BYTES sets status bit 2 (DONE) and clears OPEN. After that, data writes give no pulse and leave the count unchanged, and keyed start writes do not reopen the upgrade.
- R8: A data write made while the upgrade is not open gives no pulse and leaves the count at 0.
- R9: While OPEN, reads of any register, including the data register, and start writes neither close the upgrade nor disturb the load.
- R10: During and right after reset, `bus_rdata_o` and `img_we_o` are 0, and the status and the count both read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address (0 status, 1 start, 2 data, 3 count low, 4 count high) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| img_we_o | output | 1 | Byte strobe toward the image store |
| img_data_o | output | DATA_W | Image byte |
| img_idx_o | output | clog2(IMG_BYTES+1) | Position of the byte in the image |

## Verification
The assertions assume that the bus makes at most one access per cycle and that `bus_wr_i` and `bus_addr_i` are meaningful only while `bus_sel_i` is high. They also assume the unlock count is observed only through status reads, which themselves clear it. The stimulus drives every access for exactly one cycle from the falling edge, so the bus is never held selected across two accesses by accident. The only idle gaps it leaves are the ones a requirement calls for. The image length and lockout are shrunk through parameters, so the bench can sweep all 255 wrong key values and every byte position of a complete image.

// File: rtl/fwup_pkg.sv
package fwup_pkg;
  // register addresses; the map is part of the software contract
  localparam int unsigned A_STATUS = 0;
  localparam int unsigned A_START  = 1;
  localparam int unsigned A_DATA   = 2;
  localparam int unsigned A_CNT_LO = 3;
  localparam int unsigned A_CNT_HI = 4;

  // status bit positions
  localparam int unsigned S_READY = 0;
  localparam int unsigned S_OPEN  = 1;
  localparam int unsigned S_DONE  = 2;
  localparam int unsigned S_SEQ   = 3;  // two bits: 4:3

  localparam int unsigned SEQ_W = 2;

  function automatic int unsigned lock_cycles(input int unsigned hz, input int unsigned ms);
    int unsigned c;
    c = (hz / 1000) * ms;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/fwup_lockout.sv
module fwup_lockout #(
  parameter int unsigned LOCK_CYC = 150000
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LAST);
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LAST);

  // R1: once the lockout has elapsed it stays elapsed
  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |=> ready_o);
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/fwup_unlock.sv
module fwup_unlock #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic                       clk_i,
  input  logic                       rst_n,
  input  logic                       armed_i,
  input  logic                       acc_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [fwup_pkg::SEQ_W-1:0] seq_o,
  output logic                       open_set_o
);
  import fwup_pkg::*;

  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             seq_en;
  logic             key_wr, start_wr;

  always_comb begin
    start_wr   = acc_i && wr_i && (addr_i == ADDR_W'(A_START));
    key_wr     = start_wr && (wdata_i == KEY);
    seq_en     = !armed_i || acc_i;
    seq_d      = seq_q;
    open_set_o = 1'b0;
    if (!armed_i) begin
      seq_d = '0;
    end else if (acc_i) begin
      if (key_wr) begin
        if (seq_q == SEQ_W'(2)) begin
          seq_d      = '0;
          open_set_o = 1'b1;
        end else begin
          seq_d = seq_q + SEQ_W'(1);
        end
      end else begin
        seq_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      seq_q <= '0;
    else if (seq_en) seq_q <= seq_d;
  end

  assign seq_o = seq_q;

  // R2: no progress while not armed
  p_seq_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !armed_i |=> (seq_q == '0));
  // R4: wrong key clears the count
  p_bad_key_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_i && start_wr && (wdata_i != KEY)) |=> (seq_q == '0));
  // R5: any other access clears the count
  p_other_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_i && acc_i && !start_wr) |=> (seq_q == '0));
  p_seq_range_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    seq_q != SEQ_W'(3));
endmodule

// File: rtl/fwup_sink.sv
module fwup_sink #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IMG_BYTES = 7600,
  parameter int unsigned CNT_W     = $clog2(IMG_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              open_set_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              img_we_o,
  output logic [DATA_W-1:0] img_data_o,
  output logic [CNT_W-1:0]  img_idx_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMG_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(IMG_BYTES);

  logic              open_q, open_d, done_q, done_d, we_q, take;
  logic [CNT_W-1:0]  cnt_q, cnt_d, idx_q;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    take   = open_q && data_wr_i;
    open_d = open_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    if (open_set_i && !done_q) open_d = 1'b1;
    if (take) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == LAST_IDX) begin
        open_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      we_q   <= 1'b0;
    end else begin
      open_q <= open_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      we_q   <= take;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      dat_q <= wdata_i;
      idx_q <= cnt_q;
    end
  end

  assign open_o     = open_q;
  assign done_o     = done_q;
  assign count_o    = cnt_q;
  assign img_we_o   = we_q;
  assign img_data_o = dat_q;
  assign img_idx_o  = idx_q;

  // R6: a strobe's index is the byte just counted
  p_idx_match_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_q |-> ((idx_q + CNT_W'(1)) == cnt_q));
  // R7: count never passes the image size; done closes and sticks
  p_cnt_max_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_q <= FULL);
  p_done_shut_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |-> !open_q);
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> done_q);
  p_no_we_done_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> !we_q);
  // R8: strobes only follow an open cycle
  p_we_open_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_q |-> $past(open_q));
endmodule

// File: rtl/fwup_loader.sv
module fwup_loader #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned LOCK_MS   = 3,
  parameter int unsigned IMG_BYTES = 7600,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic                               clk_i,
  input  logic                               rst_n_i,
  input  logic                               bus_sel_i,
  input  logic                               bus_wr_i,
  input  logic [ADDR_W-1:0]                  bus_addr_i,
  input  logic [DATA_W-1:0]                  bus_wdata_i,
  output logic [DATA_W-1:0]                  bus_rdata_o,
  output logic                               img_we_o,
  output logic [DATA_W-1:0]                  img_data_o,
  output logic [$clog2(IMG_BYTES + 1)-1:0]   img_idx_o
);
  import fwup_pkg::*;

  localparam int unsigned LOCK_CYC = lock_cycles(CLK_HZ, LOCK_MS);
  localparam int unsigned CNT_W    = $clog2(IMG_BYTES + 1);
  localparam int unsigned EXT_W    = 2 * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic             ready, armed, open_set, open, done, data_wr, rd;
  logic [SEQ_W-1:0] seq;
  logic [CNT_W-1:0] count;

  fwup_lockout #(.LOCK_CYC(LOCK_CYC)) lock_i (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .ready_o(ready)
  );

  assign armed = ready && !open && !done;

  fwup_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) unl_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .armed_i   (armed),
    .acc_i     (bus_sel_i),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .seq_o     (seq),
    .open_set_o(open_set)
  );

  assign data_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(A_DATA));

  fwup_sink #(.DATA_W(DATA_W), .IMG_BYTES(IMG_BYTES), .CNT_W(CNT_W)) snk_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .open_set_i(open_set),
    .data_wr_i (data_wr),
    .wdata_i   (bus_wdata_i),
    .open_o    (open),
    .done_o    (done),
    .count_o   (count),
    .img_we_o  (img_we_o),
    .img_data_o(img_data_o),
    .img_idx_o (img_idx_o)
  );

  // read-back path
  logic [DATA_W-1:0] rdata_q, rdata_d, status;
  logic [EXT_W-1:0]  cnt_ext;

  always_comb begin
    rd     = bus_sel_i && !bus_wr_i;
    status = '0;
    status[S_READY]             = armed;
    status[S_OPEN]              = open;
    status[S_DONE]              = done;
    status[S_SEQ +: SEQ_W]      = seq;
    cnt_ext = EXT_W'(count);
    rdata_d = '0;
    if (bus_addr_i == ADDR_W'(A_STATUS))      rdata_d = status;
    else if (bus_addr_i == ADDR_W'(A_CNT_LO)) rdata_d = cnt_ext[DATA_W-1:0];
    else if (bus_addr_i == ADDR_W'(A_CNT_HI)) rdata_d = cnt_ext[EXT_W-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // R3: the upgrade opens only after two earlier keyed writes
  p_open_after_two_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(open) |-> ($past(seq) == SEQ_W'(2)));
  // R3: opening requires the lockout to have elapsed
  p_open_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    open |-> ready);
  // R9: while open, only a data write can close it
  p_open_stays_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (open && !data_wr) |=> open);
endmodule

// File: tb/fwup_loader_tb.sv
`timescale 1ns/1ps
module fwup_loader_tb_top;
  localparam int unsigned CLK_HZ = 20000;
  localparam int unsigned LOCK_MS = 3;
  localparam int unsigned LOCK_CYC = CLK_HZ / 1000 * LOCK_MS;
  localparam int unsigned IMG = 12;
  localparam int unsigned CW = $clog2(IMG + 1);
  localparam int KEYV = 'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, img_data;
  logic img_we;
  logic [CW-1:0] img_idx;

  int total = 0, bad = 0, pulses = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fwup_loader #(.CLK_HZ(CLK_HZ), .LOCK_MS(LOCK_MS), .IMG_BYTES(IMG)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .img_we_o(img_we), .img_data_o(img_data), .img_idx_o(img_idx));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int pat(input int i);
    return (i * 37 + 5) & 'hFF;
  endfunction

  function automatic int st(input int rdy, input int opn, input int dn, input int sq);
    return rdy | (opn << 1) | (dn << 2) | (sq << 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R6: byte sink monitor
  always @(negedge clk) begin
    if (rst_n && img_we) begin
      chk("R6 index", int'(img_idx), pulses);
      chk("R6 data", int'(img_data), pat(pulses));
      pulses++;
    end
  end

  task automatic wr(input int a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int v, seen;
    repeat (3) @(negedge clk);
    chk("R10 rdata in reset", int'(bus_rdata), 0);
    chk("R10 strobe in reset", int'(img_we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R10 status after reset", v, 0);
    rd(3, v); chk("R10 count after reset", v, 0);
    // R8: data write while closed
    wr(2, 'h11);
    @(negedge clk);
    chk("R8 no pulse when closed", pulses, 0);
    rd(3, v); chk("R8 count stays 0", v, 0);
    // R2: keyed start writes during lockout
    wr(1, KEYV); wr(1, KEYV); wr(1, KEYV);
    rd(0, v); chk("R2 early start ignored", v, 0);
    // R1: poll status each cycle to find when READY appears
    seen = -1;
    for (int k = 0; k < int'(LOCK_CYC) + 20 && seen < 0; k++) begin
      rd(0, v);
      if (v != 0) begin
        seen = cyc;
        chk("R1 ready value", v, st(1, 0, 0, 0));
      end
    end
    chk("R1 ready not early", int'(seen >= int'(LOCK_CYC)), 1);
    chk("R1 ready not late", int'(seen >= 0 && seen <= int'(LOCK_CYC) + 4), 1);
    // R5: partial sequences read back then cleared by the read
    for (int n = 0; n < 3; n++) begin
      for (int j = 0; j < n; j++) wr(1, KEYV);
      rd(0, v); chk("R5 count before read", v, st(1, 0, 0, n));
    end
    rd(0, v); chk("R5 read cleared count", v, st(1, 0, 0, 0));
    // R5: write to another register breaks it
    wr(1, KEYV); wr(1, KEYV); wr(3, 'h00);
    rd(0, v); chk("R5 other write clears", v, st(1, 0, 0, 0));
    // R5: read of start and data registers break it
    wr(1, KEYV); rd(1, v);
    rd(0, v); chk("R5 start read clears", v, st(1, 0, 0, 0));
    wr(1, KEYV); wr(1, KEYV); rd(2, v);
    rd(0, v); chk("R5 data read clears", v, st(1, 0, 0, 0));
    // R4: sweep every wrong key value in third position
    for (int w = 0; w < 256; w++) begin
      if (w != KEYV) begin
        wr(1, KEYV); wr(1, KEYV); wr(1, w); wr(1, KEYV);
        rd(0, v); chk("R4 wrong key resets", v, st(1, 0, 0, 1));
      end
    end
    // R3: idle cycles between keyed writes are allowed
    wr(1, KEYV); repeat (3) @(negedge clk); wr(1, KEYV);
    rd(0, v); chk("R3 idle keeps count", v, st(1, 0, 0, 2));
    wr(1, KEYV); wr(1, KEYV); repeat (2) @(negedge clk); wr(1, KEYV);
    rd(0, v); chk("R3 opened", v, st(0, 1, 0, 0));
    // R9: reads and start writes while open
    rd(2, v); rd(1, v); wr(1, KEYV); wr(1, 'h3C);
    rd(0, v); chk("R9 still open", v, st(0, 1, 0, 0));
    chk("R9 no pulse from non-data", pulses, 0);
    // R6: load the image, checking the count after each byte
    for (int i = 0; i < int'(IMG) - 1; i++) begin
      wr(2, pat(i));
      rd(3, v); chk("R6 count low", v, (i + 1) & 'hFF);
      rd(4, v); chk("R6 count high", v, (i + 1) >> 8);
      rd(2, v);
    end
    rd(0, v); chk("R6 open before last", v, st(0, 1, 0, 0));
    wr(2, pat(int'(IMG) - 1));
    @(negedge clk);
    rd(0, v); chk("R7 done", v, st(0, 0, 1, 0));
    rd(3, v); chk("R7 full count", v, int'(IMG) & 'hFF);
    // R7: later data and keyed starts are ignored
    wr(2, 'h77); wr(2, 'h78);
    wr(1, KEYV); wr(1, KEYV); wr(1, KEYV);
    @(negedge clk);
    rd(0, v); chk("R7 stays done", v, st(0, 0, 1, 0));
    rd(3, v); chk("R7 count frozen", v, int'(IMG) & 'hFF);
    chk("R7 pulse total", pulses, int'(IMG));
    summary();
  end
endmodule